// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block lets a synchronous host read single bytes from an asynchronous 64K x 8 parallel EPROM. The host offers a 16-bit address on a valid/ready handshake. The controller then drives the memory address bus, pulls the active-low chip select low and, later, the active-low output gate. It waits the number of clock edges that the memory's access times require, captures the byte and returns it with a one-cycle response strobe.

Every memory timing figure is a parameter in nanoseconds, together with the clock period. The controller converts each figure into clock edges. It keeps separate counts for the address path, the chip-select path and the output-gate path. The output gate is asserted as late as possible, so that the output-gate path finishes together with the slower of the other two. After each access the controller parks the memory in standby and keeps the host waiting until the memory's output drivers have had time to float. Four speed grades are supported: 90/90/40/35, 100/100/40/35, 120/120/50/40 and 150/150/60/45 ns (address/select/gate/float).

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `mem_ce_n` and `mem_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: While no access is in progress, both `mem_ce_n` and `mem_oe_n` stay 1 (standby). `mem_addr` keeps the last accepted address and `rsp_data` keeps the last returned byte.
- R3: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. On that edge `mem_addr` takes `req_addr` and `mem_ce_n` goes to 0. `req_ready` stays 0 until the float wait has ended. Any `req_valid`/`req_addr` activity during that time leaves `mem_addr` unchanged.
- R4: A time t ns becomes the edge count N(t) = floor(t / CLK_PERIOD_NS) + 1, which is the first edge strictly after t has elapsed. The access latency is LAT = max(N(tACC), N(tCE), N(tOE)) edges, counted from the edge that takes the request.
- R5: `mem_oe_n` falls exactly LAT - N(tOE) edges after `mem_ce_n` falls. A value of 0 means both fall on the same edge. `mem_oe_n` is never 0 while `mem_ce_n` is 1.
- R6: Exactly LAT edges after `mem_ce_n` falls, the controller captures `mem_data` into `rsp_data` and raises `rsp_valid` for exactly one cycle.
- R7: `mem_ce_n` and `mem_oe_n` both return to 1 on the same edge that raises `rsp_valid`.
- R8: `req_ready` returns to 1 exactly N(tDF) edges after that release edge. The next fall of `mem_ce_n` therefore comes more than tDF ns after the release.
- R9: The four speed grades listed above, selected through the timing parameters, each return the correct byte for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a read address |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address to read |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` is new |
| rsp_data | output | DATA_W | Byte read from the memory |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_data | input | DATA_W | Memory data bus |

## Verification
The assertions assume that the clock really runs at CLK_PERIOD_NS. They also assume the memory drives valid data no later than its stated address, select and gate times, and releases its bus within the stated float time. Nothing is assumed about the host: it may hold `req_valid` high while the controller is busy or change `req_addr` freely. The bench clock matches the period parameter, and its memory model applies exactly the nanosecond figures of each grade. Until every delay has elapsed, the model drives a corrupted byte. The bench also deliberately keeps `req_valid` high with a changing address during busy cycles.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_ACCESS = 2'd1,
        RD_FLOAT  = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
    } bus_ctl_t;

    localparam bus_ctl_t BUS_PARKED = '{ce_n: 1'b1, oe_n: 1'b1};

    // first clock edge strictly after t_ns has elapsed
    function automatic int edges_after(input int t_ns, input int period_ns);
        return (t_ns / period_ns) + 1;
    endfunction

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int width_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/eprom_rd_cnt.sv
`timescale 1ns/1ps
module eprom_rd_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (load) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/eprom_rd_seq.sv
`timescale 1ns/1ps
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int LAT     = 12,
    parameter int OE_DLY  = 6,
    parameter int FLOAT_N = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] cnt,
    output logic             req_ready,
    output logic             accept,
    output logic             sample,
    output logic             cnt_load,
    output logic             cnt_inc,
    output bus_ctl_t         bus
);
    // cnt reads j-1 on the j-th edge after a load
    localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(LAT - 1);
    localparam logic [CNT_W-1:0] FLOAT_END = CNT_W'(FLOAT_N - 1);

    rd_state_e state, state_nx;
    logic      oe_go;
    logic      float_done;

    assign req_ready  = (state == RD_IDLE);
    assign accept     = req_ready && req_valid;
    assign sample     = (state == RD_ACCESS) && (cnt == SAMPLE_AT);
    assign float_done = (state == RD_FLOAT) && (cnt == FLOAT_END);
    assign cnt_load   = accept || sample;
    assign cnt_inc    = !req_ready;

    generate
        if (OE_DLY == 0) begin : g_oe_with_ce
            assign oe_go = accept;
        end else begin : g_oe_late
            localparam logic [CNT_W-1:0] OE_AT = CNT_W'(OE_DLY - 1);
            assign oe_go = (state == RD_ACCESS) && (cnt == OE_AT);
        end
    endgenerate

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE:   if (accept)     state_nx = RD_ACCESS;
            RD_ACCESS: if (sample)     state_nx = RD_FLOAT;
            RD_FLOAT:  if (float_done) state_nx = RD_IDLE;
            default:                   state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
            bus   <= BUS_PARKED;
        end else begin
            state <= state_nx;
            if (accept) bus.ce_n <= 1'b0;
            if (oe_go)  bus.oe_n <= 1'b0;
            if (sample) bus      <= BUS_PARKED;
        end
    end
endmodule

// File: rtl/eprom_rd_capture.sv
`timescale 1ns/1ps
module eprom_rd_capture #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= sample;
            if (accept) mem_addr <= req_addr;
            if (sample) rsp_data <= mem_data;
        end
    end
endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_ACC_NS      = 90,
    parameter int T_CE_NS       = 90,
    parameter int T_OE_NS       = 40,
    parameter int T_DF_NS       = 35,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_data
);
    localparam int N_ACC  = edges_after(T_ACC_NS, CLK_PERIOD_NS);
    localparam int N_CE   = edges_after(T_CE_NS, CLK_PERIOD_NS);
    localparam int N_OE   = edges_after(T_OE_NS, CLK_PERIOD_NS);
    localparam int N_DF   = edges_after(T_DF_NS, CLK_PERIOD_NS);
    localparam int LAT    = max_of3(N_ACC, N_CE, N_OE);
    localparam int OE_DLY = LAT - N_OE;
    localparam int CNT_W  = width_for((LAT > N_DF) ? LAT : N_DF);

    logic             accept;
    logic             sample;
    logic             cnt_load;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt;
    bus_ctl_t         bus;

    eprom_rd_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (cnt_load),
        .inc   (cnt_inc),
        .value (cnt)
    );

    eprom_rd_seq #(
        .CNT_W   (CNT_W),
        .LAT     (LAT),
        .OE_DLY  (OE_DLY),
        .FLOAT_N (N_DF)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .cnt       (cnt),
        .req_ready (req_ready),
        .accept    (accept),
        .sample    (sample),
        .cnt_load  (cnt_load),
        .cnt_inc   (cnt_inc),
        .bus       (bus)
    );

    eprom_rd_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .sample    (sample),
        .mem_data  (mem_data),
        .mem_addr  (mem_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign mem_ce_n = bus.ce_n;
    assign mem_oe_n = bus.oe_n;
endmodule

// File: rtl/eprom_rd_chk.sv
`timescale 1ns/1ps
module eprom_rd_chk
    import eprom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_ACC_NS      = 90,
    parameter int T_CE_NS       = 90,
    parameter int T_OE_NS       = 40,
    parameter int T_DF_NS       = 35
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic mem_ce_n,
    input logic mem_oe_n
);
    localparam int C_LAT  = max_of3(edges_after(T_ACC_NS, CLK_PERIOD_NS),
                                    edges_after(T_CE_NS, CLK_PERIOD_NS),
                                    edges_after(T_OE_NS, CLK_PERIOD_NS));
    localparam int C_OE   = C_LAT - edges_after(T_OE_NS, CLK_PERIOD_NS);
    localparam int C_DF   = edges_after(T_DF_NS, CLK_PERIOD_NS);

    logic [15:0] since_take;
    logic [15:0] parked_for;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_take <= '0;
        end else if (req_valid && req_ready) begin
            since_take <= '0;
        end else if (!mem_ce_n && since_take != 16'hFFFF) begin
            since_take <= since_take + 16'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            parked_for <= 16'hFFFF;
        end else if (!mem_ce_n) begin
            parked_for <= '0;
        end else if (parked_for != 16'hFFFF) begin
            parked_for <= parked_for + 16'd1;
        end
    end

    assert_reset_parked_R1: assert property (@(posedge clk)
        rst |=> (mem_ce_n && mem_oe_n && !rsp_valid));

    assert_take_selects_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !mem_ce_n);

    assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !req_ready);

    assert_gate_needs_select_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);

    assert_gate_delay_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> (since_take == 16'(C_OE)));

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (since_take == 16'(C_LAT)));

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_release_both_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (mem_ce_n && mem_oe_n));

    assert_float_gap_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> (parked_for >= 16'(C_DF + 1)));
endmodule

bind eprom_rd_ctrl eprom_rd_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_ACC_NS      (T_ACC_NS),
    .T_CE_NS       (T_CE_NS),
    .T_OE_NS       (T_OE_NS),
    .T_DF_NS       (T_DF_NS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/eprom_rd_env.sv
`timescale 1ns/1ps
module eprom_rd_env #(
    parameter int          P    = 8,
    parameter int          TACC = 90,
    parameter int          TCE  = 90,
    parameter int          TOE  = 40,
    parameter int          TDF  = 35,
    parameter int unsigned SEED = 1,
    parameter int          NREQ = 40
) (
    input  logic clk,
    input  logic rst,
    output logic done,
    output int   checks,
    output int   fails
);
    function automatic int n_edges(input int t);
        return t / P + 1;
    endfunction

    localparam int E_ACC = n_edges(TACC);
    localparam int E_CE  = n_edges(TCE);
    localparam int E_OE  = n_edges(TOE);
    localparam int E_LAT = (E_ACC > E_CE) ? ((E_ACC > E_OE) ? E_ACC : E_OE)
                                          : ((E_CE > E_OE) ? E_CE : E_OE);
    localparam int E_GATE = E_LAT - E_OE;
    localparam int E_DF   = n_edges(TDF);

    function automatic logic [7:0] rom(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [15:0] mem_addr;
    logic        mem_ce_n;
    logic        mem_oe_n;
    logic [7:0]  mem_data = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    assign checks = n_chk;
    assign fails  = n_bad;

    eprom_rd_ctrl #(
        .CLK_PERIOD_NS (P),
        .T_ACC_NS      (TACC),
        .T_CE_NS       (TCE),
        .T_OE_NS       (TOE),
        .T_DF_NS       (TDF),
        .ADDR_W        (16),
        .DATA_W        (8)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_data  (mem_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s grade %0d/%0d/%0d/%0d %s: got %0d expected %0d",
                     req, TACC, TCE, TOE, TDF, what, act, exp);
        end
    endtask

    // memory model: a corrupted byte stands for undefined data until every path is met
    longint t_addr = 0;
    longint t_ce   = 0;
    longint t_oe   = 0;
    always @(mem_addr)         t_addr = $time;
    always @(negedge mem_ce_n) t_ce   = $time;
    always @(negedge mem_oe_n) t_oe   = $time;

    always begin
        #1;
        if (!mem_ce_n && !mem_oe_n && ($time - t_addr >= TACC) &&
            ($time - t_ce >= TCE) && ($time - t_oe >= TOE))
            mem_data = rom(mem_addr);
        else
            mem_data = ~rom(mem_addr);
    end

    // monitor
    int          cyc = 0;
    int          ce_cyc = 0;
    int          rel_cyc = 0;
    bit          have_rel = 0;
    bit          wait_rdy = 0;
    bit          gate_seen = 0;
    bit          prev_ce = 1;
    bit          prev_rsp = 0;
    logic [15:0] exp_addr = '0;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_ce && !mem_ce_n) begin
                ce_cyc    = cyc;
                gate_seen = 0;
                if (have_rel)
                    check((cyc - rel_cyc) * P > TDF, "R8", "ns from release to next select",
                          (cyc - rel_cyc) * P, TDF + 1);
            end
            if (!mem_ce_n && !mem_oe_n && !gate_seen) begin
                gate_seen = 1;
                check(cyc - ce_cyc == E_GATE, "R5", "edges from select to gate",
                      cyc - ce_cyc, E_GATE);
            end
            if (prev_rsp)
                check(!rsp_valid, "R6", "strobe width", rsp_valid, 0);
            if (rsp_valid) begin
                check(rsp_data == rom(exp_addr), "R9", "byte returned",
                      rsp_data, rom(exp_addr));
                check(cyc - ce_cyc == E_LAT, "R4", "edges from select to strobe",
                      cyc - ce_cyc, E_LAT);
                check(mem_ce_n && mem_oe_n, "R7", "select/gate at strobe",
                      {mem_ce_n, mem_oe_n}, 3);
                rel_cyc  = cyc;
                have_rel = 1;
                wait_rdy = 1;
            end
            if (wait_rdy && req_ready) begin
                wait_rdy = 0;
                check(cyc - rel_cyc == E_DF, "R8", "edges from release to ready",
                      cyc - rel_cyc, E_DF);
            end
            prev_ce  = mem_ce_n;
            prev_rsp = rsp_valid;
        end
    end

    // stimulus, always entered at a falling edge
    task automatic issue(input logic [15:0] a);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        exp_addr  = a;
        @(negedge clk);
        check(!mem_ce_n && mem_addr == a, "R3", "select and address after take",
              {mem_ce_n, mem_addr}, {1'b0, a});
        check(!req_ready, "R3", "ready while busy", req_ready, 0);
        for (int i = 0; i < 2; i++) begin
            req_addr = ~a ^ 16'(i);
            @(negedge clk);
            check(mem_addr == a, "R3", "address while busy", mem_addr, a);
        end
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!req_ready || !mem_ce_n) @(negedge clk);
    endtask

    initial begin
        done = 1'b0;
        void'($urandom(SEED));
        @(negedge clk);
        while (rst) @(negedge clk);
        check(mem_ce_n && mem_oe_n, "R1", "select/gate after reset", {mem_ce_n, mem_oe_n}, 3);
        check(!rsp_valid && req_ready, "R1", "strobe/ready after reset",
              {rsp_valid, req_ready}, 1);

        issue(16'h0000);
        issue(16'hFFFF);
        issue(16'h8001);
        wait_idle();
        repeat (6) @(negedge clk);
        check(mem_ce_n && mem_oe_n, "R2", "standby select/gate", {mem_ce_n, mem_oe_n}, 3);
        check(mem_addr == 16'h8001, "R2", "address held in standby", mem_addr, 16'h8001);
        check(rsp_data == rom(16'h8001), "R2", "byte held in standby",
              rsp_data, rom(16'h8001));

        for (int k = 0; k < NREQ; k++) begin
            int gap;
            gap = int'($urandom % 4);
            repeat (gap) @(negedge clk);
            issue(16'($urandom));
        end
        wait_idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
    end
endmodule

// File: tb/eprom_rd_ctrl_test.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    localparam int TACC_T [4] = '{90, 100, 120, 150};
    localparam int TCE_T  [4] = '{90, 100, 120, 150};
    localparam int TOE_T  [4] = '{40, 40, 50, 60};
    localparam int TDF_T  [4] = '{35, 35, 40, 45};

    logic [3:0] done;
    int         chk [4];
    int         bad [4];

    for (genvar g = 0; g < 4; g++) begin : grade
        eprom_rd_env #(
            .P    (8),
            .TACC (TACC_T[g]),
            .TCE  (TCE_T[g]),
            .TOE  (TOE_T[g]),
            .TDF  (TDF_T[g]),
            .SEED (32'd1234 + 32'(g)),
            .NREQ (40)
        ) u_env (
            .clk    (clk),
            .rst    (rst),
            .done   (done[g]),
            .checks (chk[g]),
            .fails  (bad[g])
        );
    end

    initial begin
        repeat (5) @(posedge clk);
        rst <= 1'b0;
    end

    initial begin
        int cycles;
        int total_c;
        int total_f;
        cycles = 0;
        while (done !== 4'hF && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        @(negedge clk);
        total_c = 0;
        total_f = 0;
        for (int g = 0; g < 4; g++) begin
            total_c += chk[g];
            total_f += bad[g];
        end
        if (done !== 4'hF) begin
            total_c++;
            total_f++;
            $display("FAIL R6 watchdog: grades done=%b expected 1111", done);
        end
        $display("TB_RESULT checks=%0d failures=%0d", total_c, total_f);
        $finish;
    end
endmodule